// File: doc/BRIEF.md
# Masked Vector Exclusive-OR Unit

This unit forms the bitwise exclusive-OR of two operand vectors. It is meant to sit in a vector execution pipeline. The active length is chosen per operation from 64, 128, 256 or 512 bits, and each result bit is 1 only where the two operand bits differ. In three-operand form the second operand can be a full vector, or one 32-bit or 64-bit scalar copied into every element. A per-element write mask, at doubleword or quadword granularity, selects which elements take the new value. Each unselected element either keeps the old destination contents or is cleared.

In legacy two-operand form the old destination is the first operand and is overwritten. Bits above the active length keep their old values. The operation is accepted on a cycle with `in_valid` high, and the result is registered. A two-state controller drives the output strobe. In `ST_IDLE`, the transition "accept" (in_valid high) moves to `ST_RESULT` and the transition "stay idle" (in_valid low) remains. In `ST_RESULT`, the transition "chain" (in_valid high) remains and the transition "retire" (in_valid low) returns to `ST_IDLE`. `out_valid` is high exactly while in `ST_RESULT`.

Top module: `vxor_unit`

## Requirements
- R1: In three-operand form with masking off and no broadcast, every result bit inside the active length equals src_a XOR src_b.
- R2: vlen encodes the active length: 0 selects 64, 1 selects 128, 2 selects 256 and 3 selects 512 bits. In three-operand form, result bits at and above the active length are 0.
- R3: In legacy form (three_op=0), result bits inside the active length equal dst_old XOR src_b, and bits above the length equal dst_old. src_a, mask_en, wr_mask, bcast and zeroing have no effect in this form.
- R4: With elem64=0 and mask_en=1, bit i of wr_mask enables result bits [32i+31:32i].
- R5: With elem64=1 and mask_en=1, bit j of wr_mask enables result bits [64j+63:64j]. Mask bits for elements beyond the active length have no effect.
- R6: With zeroing=0, an element inside the length whose mask bit is 0 takes its dst_old value (merge).
- R7: With zeroing=1, an element inside the length whose mask bit is 0 becomes all zeros.
- R8: With mask_en=0, every element inside the length is written, whatever wr_mask holds.
- R9: With bcast=1 in three-operand form, the second operand is src_b[31:0] copied to every doubleword (elem64=0), or src_b[63:0] copied to every quadword (elem64=1).
- R10: An operation accepted at a rising edge gives out_valid=1 and its result after that edge. out_valid is 1 for exactly one cycle per accepted operation, including back-to-back operations, and result holds its value while no operation is accepted.
- R11: While reset is active, and after it is released, out_valid is 0 and result is 0.
- R12: Broadcast with elem64=1 and vlen=0 yields a single 64-bit element equal to src_a[63:0] XOR src_b[63:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request |
| three_op | input | 1 | 1: three-operand form, 0: legacy two-operand form |
| mask_en | input | 1 | Apply write mask (three-operand form) |
| elem64 | input | 1 | Element size: 0 = 32-bit, 1 = 64-bit |
| vlen | input | 2 | Active length code (0..3 = 64..512 bits) |
| bcast | input | 1 | Broadcast scalar second operand |
| zeroing | input | 1 | 1: clear masked-off elements, 0: merge |
| src_a | input | 512 | First operand (three-operand form) |
| src_b | input | 512 | Second operand or scalar in low bits |
| dst_old | input | 512 | Previous destination value |
| wr_mask | input | 16 | Per-element write enables |
| out_valid | output | 1 | Result strobe, one cycle per operation |
| result | output | 512 | Registered result |

## Verification
The bench builds the unit with its default 512-bit maximum width, which gives a 16-bit mask. All four length codes can be selected at that width. Quadword masks with set bits beyond the active length therefore occur, as do chunks outside the length in both operand forms. With the full width, the bench can also compare the zero fill above the length in three-operand form against the preservation of the old destination in legacy form.

// File: rtl/vxor_pkg.sv
package vxor_pkg;
    localparam int CHUNK_W = 32;

    typedef enum logic [1:0] {
        VL_64  = 2'd0,
        VL_128 = 2'd1,
        VL_256 = 2'd2,
        VL_512 = 2'd3
    } vlen_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } state_e;
endpackage

// File: rtl/vxor_operand.sv
module vxor_operand
    import vxor_pkg::*;
#(
    parameter int VW = 512
) (
    input  logic [VW-1:0] src_b,
    input  logic          bcast,
    input  logic          elem64,
    output logic [VW-1:0] opnd_b
);
    localparam int NCH = VW / CHUNK_W;

    for (genvar c = 0; c < NCH; c++) begin : g_chunk
        logic [CHUNK_W-1:0] scalar_part;
        always_comb begin
            // quadword broadcast alternates low and high half of the scalar
            scalar_part = elem64 ? src_b[(c % 2)*CHUNK_W +: CHUNK_W]
                                 : src_b[CHUNK_W-1:0];
            opnd_b[c*CHUNK_W +: CHUNK_W] = bcast ? scalar_part
                                                 : src_b[c*CHUNK_W +: CHUNK_W];
        end
    end
endmodule

// File: rtl/vxor_lane_ctrl.sv
module vxor_lane_ctrl
    import vxor_pkg::*;
#(
    parameter int NCH = 16
) (
    input  vlen_e          vlen,
    input  logic           elem64,
    input  logic           mask_en,
    input  logic [NCH-1:0] wr_mask,
    output logic [NCH-1:0] in_rng,
    output logic [NCH-1:0] wr_en
);
    localparam int LCW = $clog2(NCH) + 2;

    logic [LCW-1:0] len_ch;

    always_comb begin
        unique case (vlen)
            VL_64:   len_ch = LCW'(2);
            VL_128:  len_ch = LCW'(4);
            VL_256:  len_ch = LCW'(8);
            VL_512:  len_ch = LCW'(16);
            default: len_ch = LCW'(2);
        endcase
    end

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic mbit;
        always_comb begin
            mbit      = elem64 ? wr_mask[c/2] : wr_mask[c];
            in_rng[c] = (LCW'(c) < len_ch);
            wr_en[c]  = in_rng[c] && (!mask_en || mbit);
        end
    end
endmodule

// File: rtl/vxor_chunk_merge.sv
module vxor_chunk_merge
    import vxor_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic [NCH*CHUNK_W-1:0] opnd_a,
    input  logic [NCH*CHUNK_W-1:0] opnd_b,
    input  logic [NCH*CHUNK_W-1:0] dst_old,
    input  logic [NCH-1:0]         in_rng,
    input  logic [NCH-1:0]         wr_en,
    input  logic                   three_op,
    input  logic                   zeroing,
    output logic [NCH*CHUNK_W-1:0] nxt
);
    for (genvar c = 0; c < NCH; c++) begin : g_merge
        logic [CHUNK_W-1:0] a_c, b_c, d_c;
        always_comb begin
            a_c = opnd_a[c*CHUNK_W +: CHUNK_W];
            b_c = opnd_b[c*CHUNK_W +: CHUNK_W];
            d_c = dst_old[c*CHUNK_W +: CHUNK_W];
            if (!three_op) begin
                nxt[c*CHUNK_W +: CHUNK_W] = in_rng[c] ? (d_c ^ b_c) : d_c;
            end else if (wr_en[c]) begin
                nxt[c*CHUNK_W +: CHUNK_W] = a_c ^ b_c;
            end else if (in_rng[c] && !zeroing) begin
                nxt[c*CHUNK_W +: CHUNK_W] = d_c;
            end else begin
                nxt[c*CHUNK_W +: CHUNK_W] = '0;
            end
        end
    end
endmodule

// File: rtl/vxor_unit.sv
module vxor_unit
    import vxor_pkg::*;
#(
    parameter int VW = 512,
    parameter int NCH = VW / 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           three_op,
    input  logic           mask_en,
    input  logic           elem64,
    input  logic [1:0]     vlen,
    input  logic           bcast,
    input  logic           zeroing,
    input  logic [VW-1:0]  src_a,
    input  logic [VW-1:0]  src_b,
    input  logic [VW-1:0]  dst_old,
    input  logic [NCH-1:0] wr_mask,
    output logic           out_valid,
    output logic [VW-1:0]  result
);
    state_e         state_q, state_d;
    logic [VW-1:0]  opnd_b;
    logic [VW-1:0]  nxt;
    logic [NCH-1:0] in_rng;
    logic [NCH-1:0] wr_en;
    vlen_e          vlen_c;

    assign vlen_c = vlen_e'(vlen);

    vxor_operand #(.VW(VW)) u_operand (
        .src_b  (src_b),
        .bcast  (bcast && three_op),
        .elem64 (elem64),
        .opnd_b (opnd_b)
    );

    vxor_lane_ctrl #(.NCH(NCH)) u_lane (
        .vlen    (vlen_c),
        .elem64  (elem64),
        .mask_en (mask_en),
        .wr_mask (wr_mask),
        .in_rng  (in_rng),
        .wr_en   (wr_en)
    );

    vxor_chunk_merge #(.NCH(NCH)) u_merge (
        .opnd_a   (src_a),
        .opnd_b   (opnd_b),
        .dst_old  (dst_old),
        .in_rng   (in_rng),
        .wr_en    (wr_en),
        .three_op (three_op),
        .zeroing  (zeroing),
        .nxt      (nxt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result register
    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= nxt;
    end

    // outputs
    always_comb begin
        out_valid = (state_q == ST_RESULT);
    end

    p_valid_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    p_valid_on_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    p_legacy_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !three_op && vlen == 2'd0) |=>
        (result[VW-1:64] == $past(dst_old[VW-1:64])));
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && three_op && vlen == 2'd0) |=> (result[VW-1:64] == '0));
endmodule

// File: tb/vxor_unit_tb_top.sv
module vxor_unit_tb_top;
    localparam int VW  = 512;
    localparam int NCH = VW / 32;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           in_valid, three_op, mask_en, elem64, bcast, zeroing;
    logic [1:0]     vlen;
    logic [VW-1:0]  src_a, src_b, dst_old;
    logic [NCH-1:0] wr_mask;
    logic           out_valid;
    logic [VW-1:0]  result;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    vxor_unit #(.VW(VW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .three_op(three_op),
        .mask_en(mask_en), .elem64(elem64), .vlen(vlen), .bcast(bcast),
        .zeroing(zeroing), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .wr_mask(wr_mask), .out_valid(out_valid), .result(result)
    );

    function automatic logic [VW-1:0] pat(input int s);
        logic [VW-1:0] v;
        for (int i = 0; i < NCH; i++)
            v[i*32 +: 32] = 32'(s) * 32'h9E3779B1 + 32'(i) * 32'h7F4A7C15 + 32'h1234;
        return v;
    endfunction

    // reference derived from the requirements, bit by bit
    function automatic logic [VW-1:0] model(input logic t3, input logic me,
            input logic e64, input logic [1:0] vl, input logic bc, input logic zr,
            input logic [VW-1:0] a, input logic [VW-1:0] b,
            input logic [VW-1:0] d, input logic [NCH-1:0] m);
        logic [VW-1:0] r;
        int nbits = 64 << vl;
        int esz = e64 ? 64 : 32;
        for (int i = 0; i < VW; i++) begin
            logic bb;
            bb = (bc && t3) ? b[i % esz] : b[i];
            if (i >= nbits)      r[i] = t3 ? 1'b0 : d[i];
            else if (!t3)        r[i] = d[i] ^ b[i];
            else if (!me || m[i / esz]) r[i] = a[i] ^ bb;
            else                 r[i] = zr ? 1'b0 : d[i];
        end
        return r;
    endfunction

    task automatic chk_vec(input string req, input logic [VW-1:0] got,
                           input logic [VW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic drive(input logic t3, input logic me, input logic e64,
            input logic [1:0] vl, input logic bc, input logic zr,
            input logic [VW-1:0] a, input logic [VW-1:0] b,
            input logic [VW-1:0] d, input logic [NCH-1:0] m);
        three_op = t3; mask_en = me; elem64 = e64; vlen = vl; bcast = bc;
        zeroing = zr; src_a = a; src_b = b; dst_old = d; wr_mask = m;
        in_valid = 1'b1;
    endtask

    // one isolated operation, checked at the following falling edges
    task automatic one_op(input string req, input logic t3, input logic me,
            input logic e64, input logic [1:0] vl, input logic bc, input logic zr,
            input logic [VW-1:0] a, input logic [VW-1:0] b,
            input logic [VW-1:0] d, input logic [NCH-1:0] m);
        logic [VW-1:0] exp;
        exp = model(t3, me, e64, vl, bc, zr, a, b, d, m);
        @(negedge clk);
        drive(t3, me, e64, vl, bc, zr, a, b, d, m);
        @(negedge clk);
        in_valid = 1'b0;
        chk_bit({req, " valid"}, out_valid, 1'b1);
        chk_vec(req, result, exp);
        @(negedge clk);
        chk_bit({req, " R10 single strobe"}, out_valid, 1'b0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0;
        drive(1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, '0, '0, '0, '0);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk_bit("R11 valid in reset", out_valid, 1'b0);
        chk_vec("R11 result in reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit("R11 valid after reset", out_valid, 1'b0);
        chk_vec("R11 result after reset", result, '0);
    endtask

    task automatic t_plain;
        one_op("R1 xor 512", 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, pat(1), pat(2), pat(3), '0);
        one_op("R1 xor ones", 1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, '1, pat(4), pat(5), '0);
    endtask

    task automatic t_length;
        one_op("R2 len 128", 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, pat(6), pat(7), '1, '1);
        one_op("R2 len 64", 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, pat(8), pat(9), '1, '1);
        one_op("R2 len 256", 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, pat(10), pat(11), '1, '1);
    endtask

    task automatic t_legacy;
        // src_a, mask, bcast, zeroing set but must have no effect
        one_op("R3 legacy 256", 1'b0, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1, pat(12), pat(13), pat(14), 16'h0000);
        one_op("R3 legacy 64", 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, '1, pat(15), pat(16), 16'h00F0);
    endtask

    task automatic t_mask;
        one_op("R4 R6 dword merge", 1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, pat(17), pat(18), pat(19), 16'hA5C3);
        one_op("R4 R7 dword zero", 1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 1'b1, pat(20), pat(21), pat(22), 16'h3C96);
        one_op("R5 R7 qword zero high mask", 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1, pat(23), pat(24), pat(25), 16'hFFA5);
        one_op("R5 R6 qword merge", 1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, pat(26), pat(27), pat(28), 16'h0059);
        one_op("R8 mask off", 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, pat(29), pat(30), pat(31), 16'h0000);
    endtask

    task automatic t_bcast;
        one_op("R9 bcast dword", 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, pat(32), pat(33), pat(34), '0);
        one_op("R9 bcast qword masked", 1'b1, 1'b1, 1'b1, 2'd3, 1'b1, 1'b0, pat(35), pat(36), pat(37), 16'h00C6);
        one_op("R12 bcast qword len 64", 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, pat(38), pat(39), pat(40), '0);
    endtask

    task automatic t_b2b;
        logic [VW-1:0] e1, e2;
        e1 = model(1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, pat(41), pat(42), pat(43), '0);
        e2 = model(1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, pat(44), pat(45), pat(46), '0);
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, pat(41), pat(42), pat(43), '0);
        @(negedge clk);
        chk_bit("R10 b2b first valid", out_valid, 1'b1);
        chk_vec("R10 b2b first result", result, e1);
        drive(1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, pat(44), pat(45), pat(46), '0);
        @(negedge clk);
        in_valid = 1'b0;
        chk_bit("R10 b2b second valid", out_valid, 1'b1);
        chk_vec("R10 b2b second result", result, e2);
        src_a = pat(47); src_b = pat(48); dst_old = pat(49);
        repeat (2) @(negedge clk);
        chk_bit("R10 idle valid", out_valid, 1'b0);
        chk_vec("R10 result held", result, e2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_plain();
        t_length();
        t_legacy();
        t_mask();
        t_bcast();
        t_b2b();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule